// File: doc/BRIEF.md
# Packed Bit-Matrix Multiplier

This unit reads two 64-bit operands as square 8x8 arrays of bits and, once per accepted request, forms either their Boolean product or their product over GF(2). It can also return the transpose of the first operand. Each byte of an operand is one row: byte `r` holds row `r`, and bit `k` of that byte is column `k`. In a product, result bit `8*r + c` depends only on row `r` of the left operand and column `c` of the right operand. Column `c` of the right operand is the set of bits `8*k + c` for `k` = 0..7.

A request is a single cycle with `inValid` high and `opSel`, `opLeft` and `opRight` stable. One clock later the result appears in an output register and `outValid` is high for one cycle. Between requests the result register keeps its last value. The matrix dimension is a parameter, and the operand width is the square of the dimension.

Top module: `bmm_unit`

## Requirements
- R1: After reset, `outValid` is 0 and `result` is all zeros.
- R2: `outValid` is high in the cycle after each cycle in which `inValid` is high, and low in the cycle after each cycle in which `inValid` is low.
- R3: `result` changes only in the cycle after an accepted request. While `inValid` is low, the output keeps its value whatever the operands and `opSel` do.
- R4: With `opSel` = 2'b10 (parity product), bit `8*r+c` of `result` is the XOR over `k` of `opLeft[8*r+k] & opRight[8*k+c]`.
- R5: With `opSel` = 2'b01 (Boolean product), bit `8*r+c` of `result` is the OR over `k` of `opLeft[8*r+k] & opRight[8*k+c]`.
- R6: With `opSel` = 2'b00 (transpose), bit `8*c+r` of `result` equals `opLeft[8*r+c]`, and `opRight` has no effect on the result.
- R7: With `opSel` = 2'b11 (reserved), `result` becomes all zeros.
- R8: In both product modes, a right operand equal to the identity 64'h8040201008040201 returns `opLeft` unchanged. A left operand equal to the identity returns `opRight` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe; operands and opSel are sampled when it is high |
| opSel | input | 2 | 00 transpose, 01 Boolean product, 10 parity product, 11 reserved |
| opLeft | input | 64 | Left matrix, byte r is row r |
| opRight | input | 64 | Right matrix, byte r is row r |
| outValid | output | 1 | High for one cycle when a new result is in `result` |
| result | output | 64 | Registered result matrix |

## Verification
The assertions assume that `inValid` is low while reset is applied, so no request is taken before the first cycle that is out of reset. The bench keeps `inValid` low until reset has been released. Every operand pair is driven on the falling edge together with its strobe and is held for the whole cycle, so the sampled values are the ones the checks expect. Stimulus sweeps every pair of single-bit left and right matrices in both product modes, and every single-bit matrix through the transpose. It then applies pseudo-random dense operands, identity operands, the reserved code, and idle cycles in which the inputs carry noise.

// File: rtl/bmm_pkg.sv
package bmm_pkg;

  typedef enum logic [1:0] {
    OP_FLIP    = 2'b00,
    OP_ORPROD  = 2'b01,
    OP_XORPROD = 2'b10,
    OP_RSVD    = 2'b11
  } bmmOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic pickFlip;
    logic pickOr;
    logic pickXor;
  } bmmStrobe_t;

endpackage

// File: rtl/bmm_ctrl.sv
module bmm_ctrl
  import bmm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] opSel,
  output bmmStrobe_t strobe,
  output logic       outValid
);

  bmmOp_e opCode;

  always_comb begin
    opCode          = bmmOp_e'(opSel);
    strobe          = '0;
    strobe.load     = inValid && rstN;
    strobe.pickFlip = inValid && (opCode == OP_FLIP);
    strobe.pickOr   = inValid && (opCode == OP_ORPROD);
    strobe.pickXor  = inValid && (opCode == OP_XORPROD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  assert_one_select_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.pickFlip, strobe.pickOr, strobe.pickXor}));

endmodule

// File: rtl/bmm_datapath.sv
module bmm_datapath
  import bmm_pkg::*;
#(
  parameter int DIM = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  bmmStrobe_t         strobe,
  input  logic [DIM*DIM-1:0] opLeft,
  input  logic [DIM*DIM-1:0] opRight,
  output logic [DIM*DIM-1:0] result
);

  localparam int W = DIM * DIM;

  function automatic logic [W-1:0] makeIdentity();
    logic [W-1:0] m;
    m = '0;
    for (int i = 0; i < DIM; i++) m[DIM*i+i] = 1'b1;
    return m;
  endfunction

  localparam logic [W-1:0] IDENT = makeIdentity();

  logic [DIM-1:0] rowOf [DIM];
  logic [DIM-1:0] colOf [DIM];
  logic [W-1:0]   flipBits;
  logic [W-1:0]   xorBits;
  logic [W-1:0]   orBits;
  logic [W-1:0]   nextResult;

  // operand decomposition: rows of the left matrix, columns of the right
  for (genvar r = 0; r < DIM; r++) begin : g_rows
    assign rowOf[r] = opLeft[DIM*r +: DIM];
    for (genvar k = 0; k < DIM; k++) begin : g_cols
      assign colOf[r][k] = opRight[DIM*k + r];
    end
  end

  // one product cell per result bit, plus the transpose wiring
  for (genvar r = 0; r < DIM; r++) begin : g_cellRow
    for (genvar c = 0; c < DIM; c++) begin : g_cell
      logic [DIM-1:0] andTerm;
      assign andTerm            = rowOf[r] & colOf[c];
      assign xorBits[DIM*r + c] = ^andTerm;
      assign orBits[DIM*r + c]  = |andTerm;
      assign flipBits[DIM*c + r] = opLeft[DIM*r + c];
    end
  end

  always_comb begin
    nextResult = ({W{strobe.pickFlip}} & flipBits)
               | ({W{strobe.pickOr}}   & orBits)
               | ({W{strobe.pickXor}}  & xorBits);
  end

  always_ff @(posedge clk) begin
    if (!rstN)            result <= '0;
    else if (strobe.load) result <= nextResult;
  end

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(result));
  assert_flip_popcount_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.pickFlip) |=> ($countones(result) == $countones($past(opLeft))));
  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.pickFlip && !strobe.pickOr && !strobe.pickXor) |=> (result == '0));
  assert_zero_right_R4_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && (strobe.pickOr || strobe.pickXor) && opRight == '0) |=> (result == '0));
  assert_identity_right_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && (strobe.pickOr || strobe.pickXor) && opRight == IDENT) |=> (result == $past(opLeft)));

endmodule

// File: rtl/bmm_unit.sv
module bmm_unit
  import bmm_pkg::*;
#(
  parameter int DIM = 8,
  localparam int W = DIM * DIM
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [1:0]   opSel,
  input  logic [W-1:0] opLeft,
  input  logic [W-1:0] opRight,
  output logic         outValid,
  output logic [W-1:0] result
);

  bmmStrobe_t strobe;

  bmm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opSel    (opSel),
    .strobe   (strobe),
    .outValid (outValid)
  );

  bmm_datapath #(.DIM(DIM)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .opLeft  (opLeft),
    .opRight (opRight),
    .result  (result)
  );

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (!outValid && result == '0));

endmodule

// File: tb/bmm_unit_test.sv
module bmm_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int DIM = 8;
  localparam int W = DIM * DIM;
  localparam logic [W-1:0] IDENT = 64'h8040201008040201;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [1:0]   opSel = 2'b00;
  logic [W-1:0] opLeft = '0;
  logic [W-1:0] opRight = '0;
  logic         outValid;
  logic [W-1:0] result;

  int vectors = 0;
  int miscompares = 0;

  bmm_unit #(.DIM(DIM)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .opLeft(opLeft), .opRight(opRight), .outValid(outValid), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] refModel(logic [1:0] op, logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] o;
    o = '0;
    for (int r = 0; r < DIM; r++) begin
      for (int c = 0; c < DIM; c++) begin
        int sum;
        sum = 0;
        for (int k = 0; k < DIM; k++) sum += int'(a[DIM*r+k] & b[DIM*k+c]);
        case (op)
          2'b00: o[DIM*c+r] = a[DIM*r+c];
          2'b01: o[DIM*r+c] = (sum != 0);
          2'b10: o[DIM*r+c] = sum[0];
          default: o[DIM*r+c] = 1'b0;
        endcase
      end
    end
    return o;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // drive one request, check the output one cycle later
  task automatic apply(string req, logic [1:0] op, logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk);
    inValid = 1'b1; opSel = op; opLeft = a; opRight = b;
    @(negedge clk);
    inValid = 1'b0;
    check({req, " valid"}, {63'd0, outValid}, 64'd1);
    check(req, result, refModel(op, a, b));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [W-1:0] held;
    logic [W-1:0] ra;
    logic [W-1:0] rb;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset result", result, '0);
    check("R1 reset valid", {63'd0, outValid}, '0);

    // R4 R5: every single-bit pair in both product modes
    for (int i = 0; i < W; i++)
      for (int j = 0; j < W; j++) begin
        apply("R5 or single-bit", 2'b01, 64'd1 << i, 64'd1 << j);
        apply("R4 xor single-bit", 2'b10, 64'd1 << i, 64'd1 << j);
      end

    // R6: every single-bit transpose, noisy right operand
    for (int i = 0; i < W; i++)
      apply("R6 transpose", 2'b00, 64'd1 << i, {$urandom(), $urandom()});

    // dense pseudo-random operands
    for (int n = 0; n < 300; n++) begin
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      apply("R4 xor dense", 2'b10, ra, rb);
      apply("R5 or dense", 2'b01, ra, rb);
      apply("R6 transpose dense", 2'b00, ra, rb);
      apply("R7 reserved", 2'b11, ra, rb);
      apply("R8 identity right xor", 2'b10, ra, IDENT);
      check("R8 identity right xor keeps left", result, ra);
      apply("R8 identity left or", 2'b01, IDENT, rb);
      check("R8 identity left or keeps right", result, rb);
      apply("R8 identity right or", 2'b01, ra, IDENT);
      apply("R8 identity left xor", 2'b10, IDENT, rb);
    end

    // R6: right operand has no effect on transpose
    ra = 64'h0123456789ABCDEF;
    apply("R6 transpose rb zero", 2'b00, ra, '0);
    held = result;
    apply("R6 transpose rb ones", 2'b00, ra, '1);
    check("R6 rb ignored", result, held);

    // R3 R2: idle cycles with noisy inputs hold the result
    held = result;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      opSel = 2'(n); opLeft = {$urandom(), $urandom()}; opRight = {$urandom(), $urandom()};
      @(negedge clk);
      check("R3 hold while idle", result, held);
      check("R2 valid low while idle", {63'd0, outValid}, '0);
    end

    // back-to-back requests
    @(negedge clk);
    inValid = 1'b1; opSel = 2'b10; opLeft = 64'hFFFF; opRight = '1;
    @(negedge clk);
    check("R2 back-to-back valid", {63'd0, outValid}, 64'd1);
    check("R4 back-to-back first", result, refModel(2'b10, 64'hFFFF, '1));
    opSel = 2'b01;
    @(negedge clk);
    inValid = 1'b0;
    check("R5 back-to-back second", result, refModel(2'b01, 64'hFFFF, '1));

    // R1: reset mid-run clears the output
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R1 reset again result", result, '0);
    check("R1 reset again valid", {63'd0, outValid}, '0);

    finishRun();
  end

endmodule